// File: doc/BRIEF.md
# Deflection Router Local Access Stage

This block is the pipeline stage that sits in front of the routing permutation of a bufferless deflection router. Each cycle it looks at the four link flit slots that arrived at the router. It removes at most one flit addressed to this node and hands that flit to the reassembly side. If a slot is left empty after that, it places one flit from the local injection queue into it. The four slots, with any changes, are registered and passed on to the permutation stage one cycle later.

Ejection is ordered by priority. A flit that belongs to the currently golden packet, whose packet identifier matches the `goldenId` input, always leaves before other local flits. Two golden flits are separated by their sequence number. Other local flits are taken by lowest port index. A local flit that is not taken stays in its slot and is deflected onward by the router. Injection only uses capacity nobody else needs. It never displaces a flit already in flight, and the queue is popped only in a cycle where its head flit is actually placed.

A flit is packed most significant field first as {dest[NODE_W], pktId[PKT_W], seq[SEQ_W], data[DATA_W]}. NUM_PORTS may be at most 8.

Top module: `ie_stage`

## Requirements
- R1: While `rstN` is low, and in the first cycle after it is released, `outValid` is all zeros and `ejValid` is 0.
- R2: A valid input flit whose dest field differs from `localId` appears unchanged in the same output slot one clock edge after it is presented.
- R3: A valid input flit whose dest field equals `localId` and is selected for ejection appears on `ejFlit` with `ejValid` high one edge later, and its slot is empty in the output.
- R4: At most one flit is ejected per cycle. Local flits that are not selected are passed to their own output slots unchanged.
- R5: If any local flit carries a pktId equal to `goldenId`, the ejected flit is one of those golden flits.
- R6: Among several local golden flits, the one with the smallest seq field is ejected. Equal seq values are resolved by the lowest port index.
- R7: When no local flit is golden, the local flit on the lowest port index is ejected.
- R8: When `injValid` is high, `injFlit` goes into the lowest-numbered slot that is empty after ejection. A slot emptied by this cycle's ejection counts as empty.
- R9: `injPop` is high in exactly the cycles where `injValid` is high and at least one slot is empty after ejection. It is low when `injValid` is low or all four slots hold flits that are not ejected.
- R10: Injection never replaces or changes a flit that stays in its slot. New traffic only takes empty slots.
- R11: The number of valid output slots plus `ejValid` equals the number of valid input slots of the previous cycle plus that cycle's `injPop`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| localId | input | NODE_W | Address of this node |
| goldenId | input | PKT_W | Packet identifier that is currently golden |
| inValid | input | NUM_PORTS | Occupancy of each incoming link slot |
| inFlit | input | NUM_PORTS*FLIT_W | Incoming flits, slot i at bits [i*FLIT_W +: FLIT_W] |
| injValid | input | 1 | Injection queue holds a flit |
| injFlit | input | FLIT_W | Head flit of the injection queue |
| injPop | output | 1 | Head flit is taken this cycle (combinational) |
| outValid | output | NUM_PORTS | Registered slot occupancy toward the permutation stage |
| outFlit | output | NUM_PORTS*FLIT_W | Registered slot contents toward the permutation stage |
| ejValid | output | 1 | Registered ejection strobe |
| ejFlit | output | FLIT_W | Registered ejected flit toward reassembly |

## Verification
The bench builds the block with its default parameters: four ports, 4-bit node addresses, 8-bit packet identifiers, 2-bit sequence numbers and 16-bit payloads. With four ports, every mix that matters can be set up directly. These include a full row of transit flits with nothing free, two or three competing local flits, golden flits with equal or different sequence numbers, and a slot freed by ejection being the only one available. The 2-bit sequence field lets the tie-break between golden flits be checked both with equal and with unequal values. The directed cases are followed by a pseudo-random run that mixes local, golden and transit flits, so that ejection and injection are also exercised together.

// File: rtl/ie_pkg.sv
package ie_pkg;

  // Width of a slot index carried in the strobe struct (up to 8 slots).
  localparam int PORT_IDX_W = 3;

  // Strobes from the control module to the datapath.
  typedef struct packed {
    logic                  ejFire;
    logic [PORT_IDX_W-1:0] ejSel;
    logic                  injFire;
    logic [PORT_IDX_W-1:0] injSel;
  } ieStrobe_t;

endpackage

// File: rtl/ie_ctrl.sv
module ie_ctrl
  import ie_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int NODE_W    = 4,
  parameter int PKT_W     = 8,
  parameter int SEQ_W     = 2
) (
  input  logic [NUM_PORTS-1:0]        inValid,
  input  logic [NUM_PORTS*NODE_W-1:0] inDest,
  input  logic [NUM_PORTS*PKT_W-1:0]  inPkt,
  input  logic [NUM_PORTS*SEQ_W-1:0]  inSeq,
  input  logic [NODE_W-1:0]           localId,
  input  logic [PKT_W-1:0]            goldenId,
  input  logic                        injValid,
  output ieStrobe_t                   strobe,
  output logic                        injPop
);

  logic [NUM_PORTS-1:0] isLocal;
  logic [NUM_PORTS-1:0] isGolden;
  logic [NUM_PORTS-1:0] freeSlot;

  // Classify each slot.
  generate
    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_class
      assign isLocal[g]  = inValid[g] && (inDest[g*NODE_W +: NODE_W] == localId);
      assign isGolden[g] = (inPkt[g*PKT_W +: PKT_W] == goldenId);
    end
  endgenerate

  // Ejection pick: golden over plain, then lower seq among golden, then lower port.
  logic                  ejFound;
  logic                  ejGold;
  logic [SEQ_W-1:0]      ejSeq;
  logic [PORT_IDX_W-1:0] ejIdx;

  always_comb begin
    ejFound = 1'b0;
    ejGold  = 1'b0;
    ejSeq   = '0;
    ejIdx   = '0;
    for (int i = 0; i < NUM_PORTS; i++) begin
      if (isLocal[i]) begin
        if (!ejFound ||
            (isGolden[i] && !ejGold) ||
            (isGolden[i] && ejGold && (inSeq[i*SEQ_W +: SEQ_W] < ejSeq))) begin
          ejFound = 1'b1;
          ejGold  = isGolden[i];
          ejSeq   = inSeq[i*SEQ_W +: SEQ_W];
          ejIdx   = PORT_IDX_W'(i);
        end
      end
    end
  end

  // Slots free after ejection.
  generate
    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_free
      assign freeSlot[g] = !inValid[g] || (ejFound && (ejIdx == PORT_IDX_W'(g)));
    end
  endgenerate

  // Injection pick: lowest free slot.
  logic                  injHit;
  logic [PORT_IDX_W-1:0] injIdx;

  always_comb begin
    injHit = 1'b0;
    injIdx = '0;
    for (int i = 0; i < NUM_PORTS; i++) begin
      if (freeSlot[i] && !injHit) begin
        injHit = 1'b1;
        injIdx = PORT_IDX_W'(i);
      end
    end
  end

  always_comb begin
    strobe.ejFire  = ejFound;
    strobe.ejSel   = ejIdx;
    strobe.injFire = injValid && injHit;
    strobe.injSel  = injIdx;
  end

  assign injPop = injValid && injHit;

endmodule

// File: rtl/ie_datapath.sv
module ie_datapath
  import ie_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int FLIT_W    = 30
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  ieStrobe_t                   strobe,
  input  logic [NUM_PORTS-1:0]        inValid,
  input  logic [NUM_PORTS*FLIT_W-1:0] inFlit,
  input  logic [FLIT_W-1:0]           injFlit,
  output logic [NUM_PORTS-1:0]        outValid,
  output logic [NUM_PORTS*FLIT_W-1:0] outFlit,
  output logic                        ejValid,
  output logic [FLIT_W-1:0]           ejFlit
);

  // Per-slot next state and register.
  generate
    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_slot
      logic              takeEj;
      logic              takeInj;
      logic              nxtValid;
      logic [FLIT_W-1:0] nxtFlit;

      assign takeEj  = strobe.ejFire  && (strobe.ejSel  == PORT_IDX_W'(g));
      assign takeInj = strobe.injFire && (strobe.injSel == PORT_IDX_W'(g));

      always_comb begin
        if (takeInj) begin
          nxtValid = 1'b1;
          nxtFlit  = injFlit;
        end else if (takeEj) begin
          nxtValid = 1'b0;
          nxtFlit  = inFlit[g*FLIT_W +: FLIT_W];
        end else begin
          nxtValid = inValid[g];
          nxtFlit  = inFlit[g*FLIT_W +: FLIT_W];
        end
      end

      always_ff @(posedge clk) begin
        if (!rstN) begin
          outValid[g]                  <= 1'b0;
          outFlit[g*FLIT_W +: FLIT_W]  <= '0;
        end else begin
          outValid[g]                  <= nxtValid;
          outFlit[g*FLIT_W +: FLIT_W]  <= nxtFlit;
        end
      end
    end
  endgenerate

  // Ejection mux.
  logic [FLIT_W-1:0] ejPick;

  always_comb begin
    ejPick = '0;
    for (int i = 0; i < NUM_PORTS; i++) begin
      if (strobe.ejSel == PORT_IDX_W'(i)) begin
        ejPick = inFlit[i*FLIT_W +: FLIT_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ejValid <= 1'b0;
      ejFlit  <= '0;
    end else begin
      ejValid <= strobe.ejFire;
      if (strobe.ejFire) begin
        ejFlit <= ejPick;
      end
    end
  end

endmodule

// File: rtl/ie_stage.sv
module ie_stage
  import ie_pkg::*;
#(
  parameter  int NUM_PORTS = 4,
  parameter  int NODE_W    = 4,
  parameter  int PKT_W     = 8,
  parameter  int SEQ_W     = 2,
  parameter  int DATA_W    = 16,
  localparam int FLIT_W    = NODE_W + PKT_W + SEQ_W + DATA_W
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NODE_W-1:0]           localId,
  input  logic [PKT_W-1:0]            goldenId,
  input  logic [NUM_PORTS-1:0]        inValid,
  input  logic [NUM_PORTS*FLIT_W-1:0] inFlit,
  input  logic                        injValid,
  input  logic [FLIT_W-1:0]           injFlit,
  output logic                        injPop,
  output logic [NUM_PORTS-1:0]        outValid,
  output logic [NUM_PORTS*FLIT_W-1:0] outFlit,
  output logic                        ejValid,
  output logic [FLIT_W-1:0]           ejFlit
);

  localparam int DEST_LSB = FLIT_W - NODE_W;
  localparam int PKT_LSB  = DEST_LSB - PKT_W;
  localparam int SEQ_LSB  = DATA_W;

  logic [NUM_PORTS*NODE_W-1:0] inDestV;
  logic [NUM_PORTS*PKT_W-1:0]  inPktV;
  logic [NUM_PORTS*SEQ_W-1:0]  inSeqV;
  ieStrobe_t                   strobe;

  // Header fields for the control side.
  generate
    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_hdr
      assign inDestV[g*NODE_W +: NODE_W] = inFlit[g*FLIT_W + DEST_LSB +: NODE_W];
      assign inPktV[g*PKT_W +: PKT_W]    = inFlit[g*FLIT_W + PKT_LSB +: PKT_W];
      assign inSeqV[g*SEQ_W +: SEQ_W]    = inFlit[g*FLIT_W + SEQ_LSB +: SEQ_W];
    end
  endgenerate

  ie_ctrl #(
    .NUM_PORTS(NUM_PORTS),
    .NODE_W   (NODE_W),
    .PKT_W    (PKT_W),
    .SEQ_W    (SEQ_W)
  ) i_ctrl (
    .inValid (inValid),
    .inDest  (inDestV),
    .inPkt   (inPktV),
    .inSeq   (inSeqV),
    .localId (localId),
    .goldenId(goldenId),
    .injValid(injValid),
    .strobe  (strobe),
    .injPop  (injPop)
  );

  ie_datapath #(
    .NUM_PORTS(NUM_PORTS),
    .FLIT_W   (FLIT_W)
  ) i_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .inValid (inValid),
    .inFlit  (inFlit),
    .injFlit (injFlit),
    .outValid(outValid),
    .outFlit (outFlit),
    .ejValid (ejValid),
    .ejFlit  (ejFlit)
  );

endmodule

// File: rtl/ie_stage_chk.sv
module ie_stage_chk #(
  parameter int NUM_PORTS = 4,
  parameter int NODE_W    = 4,
  parameter int PKT_W     = 8
) (
  input logic                        clk,
  input logic                        rstN,
  input logic [NODE_W-1:0]           localId,
  input logic [PKT_W-1:0]            goldenId,
  input logic [NUM_PORTS-1:0]        inValid,
  input logic [NUM_PORTS*NODE_W-1:0] inDest,
  input logic [NUM_PORTS*PKT_W-1:0]  inPkt,
  input logic                        injValid,
  input logic                        injPop,
  input logic [NUM_PORTS-1:0]        outValid,
  input logic                        ejValid,
  input logic [NODE_W-1:0]           ejDest,
  input logic [PKT_W-1:0]            ejPkt
);

  logic anyLocal;
  logic goldLocal;

  always_comb begin
    anyLocal  = 1'b0;
    goldLocal = 1'b0;
    for (int i = 0; i < NUM_PORTS; i++) begin
      if (inValid[i] && inDest[i*NODE_W +: NODE_W] == localId) begin
        anyLocal = 1'b1;
        if (inPkt[i*PKT_W +: PKT_W] == goldenId) goldLocal = 1'b1;
      end
    end
  end

  logic              prevOk;
  logic              prevAnyLocal;
  logic              prevGoldLocal;
  logic [NODE_W-1:0] prevLocalId;
  logic [PKT_W-1:0]  prevGoldenId;
  int                prevCount;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevOk        <= 1'b0;
      prevAnyLocal  <= 1'b0;
      prevGoldLocal <= 1'b0;
      prevLocalId   <= '0;
      prevGoldenId  <= '0;
      prevCount     <= 0;
    end else begin
      prevOk        <= 1'b1;
      prevAnyLocal  <= anyLocal;
      prevGoldLocal <= goldLocal;
      prevLocalId   <= localId;
      prevGoldenId  <= goldenId;
      prevCount     <= $countones(inValid) + (injPop ? 1 : 0);
    end
  end

  // R3: an ejected flit is addressed to this node.
  p_eject_local_r3: assert property (@(posedge clk) disable iff (!rstN)
    (prevOk && ejValid) |-> (ejDest == prevLocalId));

  // R4: a local arrival always yields an ejection next cycle.
  p_eject_when_local_r4: assert property (@(posedge clk) disable iff (!rstN)
    (prevOk && prevAnyLocal) |-> ejValid);

  // R5: golden flits leave first.
  p_golden_first_r5: assert property (@(posedge clk) disable iff (!rstN)
    (prevOk && prevGoldLocal) |-> (ejValid && ejPkt == prevGoldenId));

  // R9: no pop without a queued flit.
  p_pop_needs_valid_r9: assert property (@(posedge clk) disable iff (!rstN)
    injPop |-> injValid);

  // R9: no pop when every slot is held by a transit flit.
  p_full_no_pop_r9: assert property (@(posedge clk) disable iff (!rstN)
    ((&inValid) && !anyLocal) |-> !injPop);

  // R11: flits are neither lost nor duplicated.
  p_conserve_r11: assert property (@(posedge clk) disable iff (!rstN)
    prevOk |-> (($countones(outValid) + (ejValid ? 1 : 0)) == prevCount));

endmodule

bind ie_stage ie_stage_chk #(
  .NUM_PORTS(NUM_PORTS),
  .NODE_W   (NODE_W),
  .PKT_W    (PKT_W)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .localId (localId),
  .goldenId(goldenId),
  .inValid (inValid),
  .inDest  (inDestV),
  .inPkt   (inPktV),
  .injValid(injValid),
  .injPop  (injPop),
  .outValid(outValid),
  .ejValid (ejValid),
  .ejDest  (ejFlit[FLIT_W-1 -: NODE_W]),
  .ejPkt   (ejFlit[FLIT_W-NODE_W-1 -: PKT_W])
);

// File: tb/test_ie_stage.sv
`timescale 1ns/1ps
module test_ie_stage;

  localparam int P      = 4;
  localparam int NODE_W = 4;
  localparam int PKT_W  = 8;
  localparam int SEQ_W  = 2;
  localparam int DATA_W = 16;
  localparam int FW     = NODE_W + PKT_W + SEQ_W + DATA_W;
  localparam logic [NODE_W-1:0] LOC  = 4'd5;
  localparam logic [PKT_W-1:0]  GOLD = 8'hA3;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [NODE_W-1:0] localId = LOC;
  logic [PKT_W-1:0]  goldenId = GOLD;
  logic [P-1:0]      inValid = '0;
  logic [P*FW-1:0]   inFlit = '0;
  logic              injValid = 1'b0;
  logic [FW-1:0]     injFlit = '0;
  logic              injPop;
  logic [P-1:0]      outValid;
  logic [P*FW-1:0]   outFlit;
  logic              ejValid;
  logic [FW-1:0]     ejFlit;

  int checks = 0;
  int errors = 0;

  logic          vv[P];
  logic [FW-1:0] vf[P];

  always #2.5 clk = ~clk;

  ie_stage #(.NUM_PORTS(P), .NODE_W(NODE_W), .PKT_W(PKT_W), .SEQ_W(SEQ_W), .DATA_W(DATA_W))
    i_ie_stage (.clk(clk), .rstN(rstN), .localId(localId), .goldenId(goldenId),
      .inValid(inValid), .inFlit(inFlit), .injValid(injValid), .injFlit(injFlit),
      .injPop(injPop), .outValid(outValid), .outFlit(outFlit), .ejValid(ejValid), .ejFlit(ejFlit));

  function automatic logic [FW-1:0] mk(input logic [NODE_W-1:0] d, input logic [PKT_W-1:0] p,
                                       input logic [SEQ_W-1:0] s, input logic [DATA_W-1:0] x);
    return {d, p, s, x};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clearIn();
    for (int i = 0; i < P; i++) begin vv[i] = 1'b0; vf[i] = '0; end
    injValid = 1'b0;
    injFlit  = '0;
  endtask

  // Apply vv/vf/inj at a negedge, predict, clock once, compare.
  task automatic runCycle(input string tag);
    int ejIdx; logic ejGold; logic [SEQ_W-1:0] ejSeq;
    int injIdx;
    logic expV[P]; logic [FW-1:0] expF[P];
    int expCnt;
    for (int i = 0; i < P; i++) begin
      inValid[i] = vv[i];
      inFlit[i*FW +: FW] = vf[i];
    end
    ejIdx = -1; ejGold = 1'b0; ejSeq = '0;
    for (int i = 0; i < P; i++) begin
      logic loc, gld; logic [SEQ_W-1:0] sq;
      loc = vv[i] && (vf[i][FW-1 -: NODE_W] == LOC);
      gld = (vf[i][FW-NODE_W-1 -: PKT_W] == GOLD);
      sq  = vf[i][DATA_W +: SEQ_W];
      if (loc && (ejIdx < 0 || (gld && !ejGold) || (gld && ejGold && sq < ejSeq))) begin
        ejIdx = i; ejGold = gld; ejSeq = sq;
      end
    end
    injIdx = -1;
    for (int i = 0; i < P; i++) begin
      expV[i] = vv[i] && (i != ejIdx);
      expF[i] = vf[i];
    end
    for (int i = 0; i < P; i++) if (!expV[i] && injIdx < 0) injIdx = i;
    if (!injValid) injIdx = -1;
    if (injIdx >= 0) begin expV[injIdx] = 1'b1; expF[injIdx] = injFlit; end
    #1;
    chk({tag, " R9 injPop"}, 64'(injPop), 64'(injIdx >= 0));
    @(posedge clk);
    @(negedge clk);
    chk({tag, " R4 ejValid"}, 64'(ejValid), 64'(ejIdx >= 0));
    if (ejIdx >= 0) chk({tag, " R3 ejFlit"}, 64'(ejFlit), 64'(vf[ejIdx]));
    expCnt = 0;
    for (int i = 0; i < P; i++) begin
      chk($sformatf("%s R2 slot%0d valid", tag, i), 64'(outValid[i]), 64'(expV[i]));
      if (expV[i]) chk($sformatf("%s R10 slot%0d flit", tag, i), 64'(outFlit[i*FW +: FW]), 64'(expF[i]));
      if (expV[i]) expCnt++;
    end
    chk({tag, " R11 count"}, 64'($countones(outValid) + (ejValid ? 1 : 0)),
        64'(expCnt + (ejIdx >= 0 ? 1 : 0)));
  endtask

  task automatic tReset();
    chk("R1 outValid in reset", 64'(outValid), 64'(0));
    chk("R1 ejValid in reset", 64'(ejValid), 64'(0));
    @(negedge clk); rstN = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R1 outValid after reset", 64'(outValid), 64'(0));
    chk("R1 ejValid after reset", 64'(ejValid), 64'(0));
  endtask

  task automatic tPass();
    clearIn();
    for (int i = 0; i < P; i++) begin vv[i] = 1'b1; vf[i] = mk(4'(i), 8'(16 + i), 2'(i), 16'(16'h1000 + i)); end
    runCycle("R2 full transit");
    clearIn(); vv[1] = 1'b1; vf[1] = mk(4'd9, 8'h44, 2'd1, 16'hBEEF);
    runCycle("R2 single transit");
  endtask

  task automatic tSingleEject();
    clearIn(); vv[2] = 1'b1; vf[2] = mk(LOC, 8'h11, 2'd0, 16'hCAFE);
    vv[0] = 1'b1; vf[0] = mk(4'd3, 8'h12, 2'd0, 16'h0001);
    runCycle("R3 one local");
  endtask

  task automatic tPlainLowest();
    clearIn();
    vv[1] = 1'b1; vf[1] = mk(LOC, 8'h21, 2'd0, 16'h1111);
    vv[3] = 1'b1; vf[3] = mk(LOC, 8'h22, 2'd0, 16'h3333);
    vv[2] = 1'b1; vf[2] = mk(4'd1, 8'h23, 2'd0, 16'h2222);
    runCycle("R7 R4 two plain locals");
  endtask

  task automatic tGolden();
    clearIn();
    vv[0] = 1'b1; vf[0] = mk(LOC, 8'h31, 2'd0, 16'h0A0A);
    vv[2] = 1'b1; vf[2] = mk(LOC, GOLD, 2'd2, 16'h0B0B);
    runCycle("R5 golden beats lower port");
  endtask

  task automatic tGoldenSeq();
    clearIn();
    vv[1] = 1'b1; vf[1] = mk(LOC, GOLD, 2'd3, 16'h0101);
    vv[3] = 1'b1; vf[3] = mk(LOC, GOLD, 2'd1, 16'h0303);
    vv[0] = 1'b1; vf[0] = mk(LOC, 8'h55, 2'd0, 16'h0000);
    runCycle("R6 lower seq wins");
    clearIn();
    vv[2] = 1'b1; vf[2] = mk(LOC, GOLD, 2'd2, 16'h0202);
    vv[3] = 1'b1; vf[3] = mk(LOC, GOLD, 2'd2, 16'h0303);
    runCycle("R6 equal seq lower port");
  endtask

  task automatic tInject();
    clearIn();
    vv[0] = 1'b1; vf[0] = mk(4'd1, 8'h61, 2'd0, 16'h6000);
    vv[1] = 1'b1; vf[1] = mk(4'd2, 8'h62, 2'd0, 16'h6001);
    injValid = 1'b1; injFlit = mk(4'd7, 8'h70, 2'd0, 16'h7777);
    runCycle("R8 lowest empty slot");
    clearIn();
    for (int i = 0; i < P; i++) begin vv[i] = 1'b1; vf[i] = mk(4'd2, 8'(i), 2'd0, 16'(i)); end
    vf[1] = mk(LOC, 8'h81, 2'd0, 16'h8181);
    injValid = 1'b1; injFlit = mk(4'd8, 8'h71, 2'd1, 16'h7171);
    runCycle("R8 slot freed by ejection");
  endtask

  task automatic tNoPop();
    clearIn();
    for (int i = 0; i < P; i++) begin vv[i] = 1'b1; vf[i] = mk(4'd0, 8'(i), 2'd0, 16'(i)); end
    injValid = 1'b1; injFlit = mk(4'd8, 8'h72, 2'd0, 16'h7272);
    runCycle("R9 full no pop");
    clearIn(); vv[3] = 1'b1; vf[3] = mk(4'd1, 8'h01, 2'd0, 16'h1);
    runCycle("R9 no queued flit");
  endtask

  task automatic tNoDisplace();
    clearIn();
    for (int i = 0; i < 3; i++) begin vv[i] = 1'b1; vf[i] = mk(4'd6, 8'(i + 90), 2'd0, 16'(i + 90)); end
    injValid = 1'b1; injFlit = mk(4'd6, 8'h73, 2'd0, 16'h7373);
    runCycle("R10 only top slot free");
  endtask

  task automatic tRandom();
    logic [31:0] lf = 32'h1234_5678;
    for (int n = 0; n < 300; n++) begin
      clearIn();
      for (int i = 0; i < P; i++) begin
        lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
        vv[i] = lf[0];
        vf[i] = mk(lf[1] ? LOC : 4'(lf[5:2]), lf[7:6] == 2'b11 ? GOLD : 8'(lf[15:8]),
                   2'(lf[17:16]), 16'(lf[31:16] ^ 16'(n)));
      end
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      injValid = lf[3];
      injFlit  = mk(4'(lf[11:8]), 8'(lf[19:12]), 2'(lf[21:20]), 16'(n));
      runCycle("R11 random mix");
    end
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    clearIn();
    repeat (3) @(negedge clk);
    tReset();
    tPass();
    tSingleEject();
    tPlainLowest();
    tGolden();
    tGoldenSeq();
    tInject();
    tNoPop();
    tNoDisplace();
    tRandom();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule